// File: doc/BRIEF.md
# Prioritized Multi-Matcher Pipeline Stage

This block is one link in a chain of matching stages that all see the same byte stream. Each stage takes a byte and a vector of class-membership bits from the stage before it. That vector is worked out upstream from the same byte by a shared classifier. The stage registers the byte and the vector and hands them on to the next stage, so each connection only reaches the next stage. Inside the stage, a set of small automata each look for a fixed sequence of byte tests. Each test is one of four kinds:

- a single byte value
- a choice of two byte values
- one bit of the class vector
- any byte

Any test can also be inverted.

Several automata may finish on the same byte. A priority encoder then reduces their hits to at most one reported result per cycle, identified by a 4-bit index. When none of the local automata fires, the result registered from the upstream stage is passed on instead. This keeps one result stream for the whole pipeline.

Top module: `pipe_match_stage`

## Requirements
- R1: While `rst_ni` is low, `valid_o` and `match_valid_o` are 0 and `char_o` and `cc_o` are 0. All automaton progress is forgotten, so no sequence started before reset can complete after it.
- R2: `valid_o` equals `valid_i` one clock later. `char_o` and `cc_o` take `char_i` and `cc_i` one clock after a beat with `valid_i` high, and hold their value after a beat with `valid_i` low.
- R3: A test is a 19-bit code. Bits [18:17] give the kind: 0 means equal to A, 1 means equal to A or B, 2 means class bit, 3 means any byte. Bit 16 inverts the outcome. Bits [15:8] hold B and bits [7:0] hold A.
- R4: A class test reads `cc_i` bit (A mod `CC_W`) of the same beat.
- R5: Matcher m, of length L, fires on a valid beat when the last L valid beats satisfy its tests. Its first test applies to the oldest of those beats. Beats with `valid_i` low neither advance nor break a partial sequence. A hit is reported together with `valid_o` for that byte.
- R6: When several matchers fire on the same beat, `match_valid_o` is 1 and `match_id_o` is the lowest firing index.
- R7: When no local matcher fires, `match_valid_o` and `match_id_o` repeat `match_valid_i` and `match_id_i` from one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Byte on `char_i` is valid |
| char_i | input | 8 | Byte from previous stage |
| cc_i | input | CC_W | Class bits for `char_i` |
| match_valid_i | input | 1 | Upstream result valid |
| match_id_i | input | 4 | Upstream result index |
| valid_o | output | 1 | Registered valid |
| char_o | output | 8 | Registered byte |
| cc_o | output | CC_W | Registered class bits |
| match_valid_o | output | 1 | Stage result valid |
| match_id_o | output | 4 | Stage result index |

## Verification
Every output of the stage is due exactly one rising edge after the beat that causes it. This holds for the forwarded byte and class bits, for a local hit ending on that byte, and for a passed-through upstream result. The bench drives each beat at a falling edge and checks that beat's expected outputs at the next falling edge, before it drives the following beat. The expected hits come from a history of the last three valid bytes kept in the bench. Gaps in `valid_i` leave that history unchanged, as R5 requires.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int CHAR_W       = 8;
  localparam int ELEM_W       = 19;
  localparam int ID_W         = 4;
  localparam int MAX_MATCHERS = 16;

  typedef enum logic [1:0] {
    EK_ONE   = 2'd0,
    EK_TWO   = 2'd1,
    EK_CLASS = 2'd2,
    EK_ANY   = 2'd3
  } elem_kind_e;

  typedef struct packed {
    elem_kind_e        kind;
    logic              neg;
    logic [CHAR_W-1:0] val_b;
    logic [CHAR_W-1:0] val_a;
  } elem_t;
endpackage

// File: rtl/pms_elem_match.sv
module pms_elem_match
  import pms_pkg::*;
#(
  parameter int                CC_W = 8,
  parameter logic [ELEM_W-1:0] ELEM = '0
) (
  input  logic [CHAR_W-1:0] char_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic              hit_o
);
  localparam elem_t      E    = elem_t'(ELEM);
  localparam elem_kind_e KIND = E.kind;
  localparam int         CIDX = int'(E.val_a) % CC_W;

  logic raw;

  always_comb begin
    case (KIND)
      EK_ONE:   raw = (char_i == E.val_a);
      EK_TWO:   raw = (char_i == E.val_a) || (char_i == E.val_b);
      EK_CLASS: raw = cc_i[CIDX];
      default:  raw = 1'b1;
    endcase
  end

  assign hit_o = raw ^ E.neg;
endmodule

// File: rtl/pms_nfa.sv
module pms_nfa
  import pms_pkg::*;
#(
  parameter int                        CC_W    = 8,
  parameter int                        MAX_LEN = 4,
  parameter int                        LEN     = 1,
  parameter logic [MAX_LEN*ELEM_W-1:0] ELEMS   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic              fire_o
);
  logic [LEN-1:0] el_hit;
  logic [LEN-1:0] st_q;

  for (genvar i = 0; i < LEN; i++) begin : g_el
    pms_elem_match #(
      .CC_W(CC_W),
      .ELEM(ELEMS[i*ELEM_W +: ELEM_W])
    ) u_el (
      .char_i(char_i),
      .cc_i  (cc_i),
      .hit_o (el_hit[i])
    );
  end

  // state i set: tests 0..i passed on the last i+1 valid beats
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (valid_i) begin
      st_q[0] <= el_hit[0];
      for (int i = 1; i < LEN; i++) st_q[i] <= st_q[i-1] & el_hit[i];
    end
  end

  assign fire_o = st_q[LEN-1];
endmodule

// File: rtl/pms_prio_enc.sv
module pms_prio_enc
  import pms_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]    req_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    valid_o = |req_i;
    id_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/pipe_match_stage.sv
module pipe_match_stage
  import pms_pkg::*;
#(
  parameter int CC_W    = 8,
  parameter int NUM_M   = 4,
  parameter int MAX_LEN = 4,
  parameter logic [NUM_M*4-1:0] LENS = {4'd3, 4'd1, 4'd2, 4'd2},
  // matcher m at [m*MAX_LEN*ELEM_W +:], test 0 (oldest byte) lowest
  parameter logic [NUM_M*MAX_LEN*ELEM_W-1:0] PATTERNS = {
    19'h00000, 19'h0007A, 19'h40003, 19'h1000A,  // m3: !LF, class3, 'z'
    19'h00000, 19'h00000, 19'h00000, 19'h00062,  // m2: 'b'
    19'h00000, 19'h00000, 19'h27978, 19'h40000,  // m1: class0, 'x'|'y'
    19'h00000, 19'h00000, 19'h00062, 19'h00061   // m0: 'a','b'
  }
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic              match_valid_i,
  input  logic [ID_W-1:0]   match_id_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] char_o,
  output logic [CC_W-1:0]   cc_o,
  output logic              match_valid_o,
  output logic [ID_W-1:0]   match_id_o
);
  localparam int PAT_W = MAX_LEN * ELEM_W;

  logic [NUM_M-1:0] fire;
  logic [NUM_M-1:0] req;
  logic             own_v;
  logic [ID_W-1:0]  own_id;
  logic             valid_q;
  logic [CHAR_W-1:0] char_q;
  logic [CC_W-1:0]  cc_q;
  logic             up_v_q;
  logic [ID_W-1:0]  up_id_q;

  for (genvar m = 0; m < NUM_M; m++) begin : g_m
    localparam int RAW_L = int'(LENS[m*4 +: 4]);
    localparam int L = (RAW_L < 1) ? 1 : ((RAW_L > MAX_LEN) ? MAX_LEN : RAW_L);
    pms_nfa #(
      .CC_W   (CC_W),
      .MAX_LEN(MAX_LEN),
      .LEN    (L),
      .ELEMS  (PATTERNS[m*PAT_W +: PAT_W])
    ) u_nfa (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(valid_i),
      .char_i (char_i),
      .cc_i   (cc_i),
      .fire_o (fire[m])
    );
  end

  // a held state only counts on the beat that completed it
  assign req = fire & {NUM_M{valid_q}};

  pms_prio_enc #(.N(NUM_M)) u_enc (
    .req_i  (req),
    .valid_o(own_v),
    .id_o   (own_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      char_q  <= '0;
      cc_q    <= '0;
      up_v_q  <= 1'b0;
      up_id_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        char_q <= char_i;
        cc_q   <= cc_i;
      end
      up_v_q  <= match_valid_i;
      up_id_q <= match_id_i;
    end
  end

  assign valid_o       = valid_q;
  assign char_o        = char_q;
  assign cc_o          = cc_q;
  assign match_valid_o = own_v | up_v_q;
  assign match_id_o    = own_v ? own_id : up_id_q;
endmodule

// File: rtl/pms_checker.sv
module pms_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [7:0] char_i,
  input logic       match_valid_i,
  input logic [3:0] match_id_i,
  input logic       valid_o,
  input logic [7:0] char_o,
  input logic       match_valid_o,
  input logic [3:0] match_id_o
);
  // R2
  valid_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R2
  char_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (char_o == $past(char_i)));
  // R2
  char_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(char_o));
  // R7
  up_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_valid_i |=> match_valid_o);
  // R7
  up_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && match_valid_i) |=> (match_id_o == $past(match_id_i)));
  // R5
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !match_valid_i) |=> !match_valid_o);
endmodule

bind pipe_match_stage pms_checker u_pms_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .char_i       (char_i),
  .match_valid_i(match_valid_i),
  .match_id_i   (match_id_i),
  .valid_o      (valid_o),
  .char_o       (char_o),
  .match_valid_o(match_valid_o),
  .match_id_o   (match_id_o)
);

// File: tb/pipe_match_stage_bench.sv
module pipe_match_stage_bench;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] char_i = '0;
  logic [7:0] cc_i = '0;
  logic       match_valid_i = 1'b0;
  logic [3:0] match_id_i = '0;
  logic       valid_o;
  logic [7:0] char_o;
  logic [7:0] cc_o;
  logic       match_valid_o;
  logic [3:0] match_id_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [7:0] h0 = '0, h1 = '0, h2 = '0;
  int         nval = 0;
  logic       exp_v = 0, exp_mv = 0, exp_own = 0;
  logic [7:0] exp_ch = '0, exp_cc = '0;
  logic [3:0] exp_id = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  pipe_match_stage u_pipe_match_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .char_i(char_i),
    .cc_i(cc_i), .match_valid_i(match_valid_i), .match_id_i(match_id_i),
    .valid_o(valid_o), .char_o(char_o), .cc_o(cc_o),
    .match_valid_o(match_valid_o), .match_id_o(match_id_o)
  );

  // class vector: bit0 digit, bit3 lowercase hex letter, others the raw byte bit
  function automatic logic [7:0] ccf(input logic [7:0] c);
    logic [7:0] r;
    r    = c;
    r[0] = (c >= 8'h30) && (c <= 8'h39);
    r[3] = (c >= 8'h61) && (c <= 8'h66);
    return r;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_outs();
    string t;
    chk({7'd0, valid_o}, {7'd0, exp_v}, "R2 valid_o");
    chk(char_o, exp_ch, "R2 char_o");
    chk(cc_o, exp_cc, "R4 cc_o");
    if (!exp_own)                       t = "R7 upstream";
    else if (exp_id == 1 || exp_id == 3) t = "R3/R4 class and compare tests";
    else if (exp_id == 0)               t = "R6 priority";
    else                                t = "R5 sequence";
    chk({7'd0, match_valid_o}, {7'd0, exp_mv}, t);
    if (exp_mv) chk({4'd0, match_id_o}, {4'd0, exp_id}, t);
  endtask

  task automatic step(input logic v, input logic [7:0] ch, input logic uv, input logic [3:0] uid);
    logic [3:0] hit;
    @(negedge clk_i);
    check_outs();
    hit = '0;
    if (v) begin
      h2 = h1; h1 = h0; h0 = ch; nval++;
      hit[0] = (nval >= 2) && (h1 == 8'h61) && (h0 == 8'h62);
      hit[1] = (nval >= 2) && ccf(h1)[0] && (h0 == 8'h78 || h0 == 8'h79);
      hit[2] = (nval >= 1) && (h0 == 8'h62);
      hit[3] = (nval >= 3) && (h2 != 8'h0A) && ccf(h1)[3] && (h0 == 8'h7A);
      exp_ch = ch;
      exp_cc = ccf(ch);
    end
    exp_v   = v;
    exp_own = |hit;
    exp_mv  = exp_own | uv;
    if (hit[0])      exp_id = 4'd0;
    else if (hit[1]) exp_id = 4'd1;
    else if (hit[2]) exp_id = 4'd2;
    else if (hit[3]) exp_id = 4'd3;
    else             exp_id = uid;
    valid_i = v; char_i = ch; cc_i = ccf(ch);
    match_valid_i = uv; match_id_i = uid;
  endtask

  task automatic model_reset();
    h0 = '0; h1 = '0; h2 = '0; nval = 0;
    exp_v = 0; exp_mv = 0; exp_own = 0; exp_ch = '0; exp_cc = '0; exp_id = '0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] alph [8];
    int beat;
    alph = '{8'h61, 8'h62, 8'h78, 8'h79, 8'h7A, 8'h30, 8'h35, 8'h0A};
    beat = 0;
    repeat (3) @(negedge clk_i);
    // R1 outputs cleared in reset
    check_outs();
    rst_ni = 1'b1;

    // sweep every byte triple with periodic gaps and upstream traffic
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 8; k++) begin
          logic [7:0] tri_c [3];
          tri_c = '{alph[i], alph[j], alph[k]};
          for (int s = 0; s < 3; s++) begin
            if (beat % 7 == 6) step(1'b0, 8'hA5, beat % 3 == 0, 4'(beat + 5));
            step(1'b1, tri_c[s], beat % 5 == 0, 4'(beat));
            beat++;
          end
        end

    // R5 gaps do not break a partial sequence: 'a', gap, gap, 'b'
    step(1'b1, 8'h61, 1'b0, 4'd0);
    step(1'b0, 8'h61, 1'b0, 4'd0);
    step(1'b0, 8'h00, 1'b0, 4'd0);
    step(1'b1, 8'h62, 1'b1, 4'd9);
    step(1'b0, 8'h00, 1'b0, 4'd0);

    // R1 reset mid-sequence: 'a' then reset, then 'b' must give id 2, not 0
    step(1'b1, 8'h61, 1'b0, 4'd0);
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0; match_valid_i = 1'b0;
    @(negedge clk_i);
    model_reset();
    check_outs();
    rst_ni = 1'b1;
    step(1'b1, 8'h62, 1'b0, 4'd0);
    step(1'b0, 8'h00, 1'b0, 4'd0);
    step(1'b0, 8'h00, 1'b0, 4'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule